// File: doc/BRIEF.md
# Ring-Counter Instruction Sequencer and Decoder

This block is the control unit of a small accumulator processor with 16-bit instructions. A three-bit one-hot ring counter steps each instruction through three phases: fetch, decode and execute. After execute it returns to fetch. The opcode sits in the top nibble of the instruction register. Two cascaded 3-to-8 decoders turn it into one of sixteen one-hot instruction lines. The bottom eight bits hold the immediate value or the memory/jump address, and the datapath consumes them directly.

Each instruction line is ANDed with the phase lines to form the datapath control word. That word holds:
- the ALU function code;
- the PC source code and load enable;
- the address-bus output enables;
- the operand source code;
- the write strobes for the accumulator, the instruction register and data memory.

Several of these fields are codes for tri-state buffer enables rather than plain multiplexer selects, so each field has an "off" code. The accumulator zero flag comes in from the datapath and decides the conditional jumps.

Top module: `ring_ctl_unit`

## Requirements
- R1: A synchronous active-high reset puts the phase output into the fetch state 3'b001 at the next rising edge. Phase bit 0 is fetch, bit 1 is decode and bit 2 is execute.
- R2: Outside reset, the phase output always has exactly one bit set and advances fetch, decode, execute, fetch on successive edges.
- R3: In fetch, the outputs are fixed regardless of opcode or zero flag:
  - `pc_addr_oe`=1, `ir_load`=1, `pc_load`=1 and `pc_src`=2'b01 (PC+1);
  - `alu_fn`=2'b11 (off), `opd_sel`=2'b10 (off);
  - every other strobe and enable is 0.
- R4: In decode, no strobe or enable is active: `alu_fn`=2'b11, `pc_src`=2'b10 (off), `opd_sel`=2'b10, and all single-bit outputs are 0.
- R5: Opcodes are taken from bits 15:12. The immediate group uses `opd_sel`=2'b01 (IR immediate) and `acc_load`=1 in execute, with these ALU settings:

  | Opcode | Operation | `alu_fn` | `alu_sub` |
  |---|---|---|---|
  | 0 | load | 2'b10 (pass) | 0 |
  | 1 | add | 2'b00 | 0 |
  | 2 | subtract | 2'b00 | 1 |
  | 3 | AND | 2'b01 | 0 |

- R6: Opcode 4 (load from address) in execute drives `ir_addr_oe`=1, `opd_sel`=2'b00 (RAM), `alu_fn`=2'b10 and `acc_load`=1.
- R7: Opcode 5 (store to address) in execute drives `ir_addr_oe`=1 and `mem_we`=1, with `acc_load`=0, `alu_fn`=2'b11 and `opd_sel`=2'b10.
- R8: Opcode 8 (jump) in execute drives `pc_load`=1 with `pc_src`=2'b00 (IR address).
- R9: Opcode 9 jumps only when `acc_zero`=1, and opcode A only when `acc_zero`=0. An untaken jump leaves `pc_load`=0 and `pc_src`=2'b10.
- R10: Opcodes 6, 7 and B to F act as no-ops in execute, with the same outputs as decode. `acc_zero` has no effect on any output except for opcodes 9 and A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction register contents |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| phase | output | 3 | One-hot phase: bit0 fetch, bit1 decode, bit2 execute |
| alu_fn | output | 2 | 00 add/sub, 01 AND, 10 pass, 11 off |
| alu_sub | output | 1 | Subtract when alu_fn is 00 |
| pc_src | output | 2 | 00 IR address, 01 PC+1, 1x off |
| pc_load | output | 1 | PC register load enable |
| pc_addr_oe | output | 1 | PC drives the address bus |
| ir_addr_oe | output | 1 | IR address field drives the address bus |
| opd_sel | output | 2 | 00 RAM, 01 IR immediate, 1x off |
| acc_load | output | 1 | Accumulator write strobe |
| ir_load | output | 1 | Instruction register write strobe |
| mem_we | output | 1 | Data memory write strobe |

## Verification
The assertions take two things for granted:
- `instr` holds steady for a whole instruction, which the instruction register ensures because it loads only in fetch;
- `acc_zero` is a clean level during execute.

The bench drives both inputs only at falling edges at the start of a fetch phase and holds them for three cycles. It then sweeps every opcode with both zero-flag values and varied low bytes. One reset is applied in the middle of an instruction, after which the sequence restarts at a phase boundary.

// File: rtl/ring_ctl_unit.sv
module ring_ctl_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] instr,
  input  logic        acc_zero,
  output logic [2:0]  phase,
  output logic [1:0]  alu_fn,
  output logic        alu_sub,
  output logic [1:0]  pc_src,
  output logic        pc_load,
  output logic        pc_addr_oe,
  output logic        ir_addr_oe,
  output logic [1:0]  opd_sel,
  output logic        acc_load,
  output logic        ir_load,
  output logic        mem_we
);

  logic [2:0]  ring;
  logic [7:0]  dec_lo, dec_hi;
  logic [15:0] op;
  logic        fe, ex, take, imm;

  always_ff @(posedge clk) begin
    if (rst) ring <= 3'b001;
    else     ring <= {ring[1:0], ring[2]};
  end

  assign dec_lo = instr[15] ? 8'h00 : (8'h01 << instr[14:12]);
  assign dec_hi = instr[15] ? (8'h01 << instr[14:12]) : 8'h00;
  assign op     = {dec_hi, dec_lo};

  assign fe   = ring[0];
  assign ex   = ring[2];
  assign imm  = op[0] | op[1] | op[2] | op[3];
  assign take = ex & (op[8] | (op[9] & acc_zero) | (op[10] & ~acc_zero));

  assign phase      = ring;
  assign alu_fn     = (ex & (op[0] | op[4])) ? 2'b10 :
                      (ex & (op[1] | op[2])) ? 2'b00 :
                      (ex & op[3])           ? 2'b01 : 2'b11;
  assign alu_sub    = ex & op[2];
  assign pc_load    = fe | take;
  assign pc_src     = fe ? 2'b01 : (take ? 2'b00 : 2'b10);
  assign pc_addr_oe = fe;
  assign ir_addr_oe = ex & (op[4] | op[5]);
  assign opd_sel    = (ex & imm) ? 2'b01 : ((ex & op[4]) ? 2'b00 : 2'b10);
  assign acc_load   = ex & (imm | op[4]);
  assign ir_load    = fe;
  assign mem_we     = ex & op[5];

endmodule

// File: rtl/ring_ctl_unit_chk.sv
module ring_ctl_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] instr,
  input logic        acc_zero,
  input logic [2:0]  phase,
  input logic [1:0]  pc_src,
  input logic        pc_load,
  input logic        acc_load,
  input logic        ir_load,
  input logic        mem_we
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) rst |=> phase == 3'b001);

  // R2
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot(phase));

  // R2
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'b001) |=> (phase == 3'b010));

  // R3
  fetch_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> (phase == 3'b001) && pc_load && (pc_src == 2'b01));

  // R4
  decode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'b010) |-> !pc_load && !acc_load && !mem_we && !ir_load);

  // R7
  store_excl_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> phase[2] && !acc_load);

  // R9
  jz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase[2] && instr[15:12] == 4'h9 && !acc_zero) |-> !pc_load);

endmodule

bind ring_ctl_unit ring_ctl_unit_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .acc_zero(acc_zero), .phase(phase),
  .pc_src(pc_src), .pc_load(pc_load), .acc_load(acc_load),
  .ir_load(ir_load), .mem_we(mem_we)
);

// File: tb/sim_ring_ctl_unit.sv
module sim_ring_ctl_unit;
  logic clk = 0, rst = 1, acc_zero = 0;
  logic [15:0] instr = 16'h0000;
  logic [2:0] phase;
  logic [1:0] alu_fn, pc_src, opd_sel;
  logic alu_sub, pc_load, pc_addr_oe, ir_addr_oe, acc_load, ir_load, mem_we;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ring_ctl_unit u0 (.*);

  function automatic logic [15:0] pack(input logic [2:0] ph, input logic [1:0] af,
    input logic sb, input logic [1:0] ps, input logic pl, input logic po,
    input logic io, input logic [1:0] os, input logic al, input logic il, input logic mw);
    return {ph, af, sb, ps, pl, po, io, os, al, il, mw};
  endfunction

  function automatic logic [15:0] actual();
    return pack(phase, alu_fn, alu_sub, pc_src, pc_load, pc_addr_oe, ir_addr_oe,
                opd_sel, acc_load, ir_load, mem_we);
  endfunction

  function automatic logic [15:0] exp_exec(input logic [3:0] opc, input logic z);
    case (opc)
      4'h0: return pack(3'b100, 2'b10, 0, 2'b10, 0, 0, 0, 2'b01, 1, 0, 0);
      4'h1: return pack(3'b100, 2'b00, 0, 2'b10, 0, 0, 0, 2'b01, 1, 0, 0);
      4'h2: return pack(3'b100, 2'b00, 1, 2'b10, 0, 0, 0, 2'b01, 1, 0, 0);
      4'h3: return pack(3'b100, 2'b01, 0, 2'b10, 0, 0, 0, 2'b01, 1, 0, 0);
      4'h4: return pack(3'b100, 2'b10, 0, 2'b10, 0, 0, 1, 2'b00, 1, 0, 0);
      4'h5: return pack(3'b100, 2'b11, 0, 2'b10, 0, 0, 1, 2'b10, 0, 0, 1);
      4'h8: return pack(3'b100, 2'b11, 0, 2'b00, 1, 0, 0, 2'b10, 0, 0, 0);
      4'h9: return z ? pack(3'b100, 2'b11, 0, 2'b00, 1, 0, 0, 2'b10, 0, 0, 0)
                     : pack(3'b100, 2'b11, 0, 2'b10, 0, 0, 0, 2'b10, 0, 0, 0);
      4'hA: return !z ? pack(3'b100, 2'b11, 0, 2'b00, 1, 0, 0, 2'b10, 0, 0, 0)
                      : pack(3'b100, 2'b11, 0, 2'b10, 0, 0, 0, 2'b10, 0, 0, 0);
      default: return pack(3'b100, 2'b11, 0, 2'b10, 0, 0, 0, 2'b10, 0, 0, 0);
    endcase
  endfunction

  function automatic string exec_tag(input logic [3:0] opc);
    case (opc)
      4'h0, 4'h1, 4'h2, 4'h3: return "R5";
      4'h4: return "R6";
      4'h5: return "R7";
      4'h8: return "R8";
      4'h9, 4'hA: return "R9";
      default: return "R10";
    endcase
  endfunction

  localparam logic [15:0] FETCH_W  = 16'b001_11_0_01_1_1_0_10_0_1_0;
  localparam logic [15:0] DECODE_W = 16'b010_11_0_10_0_0_0_10_0_0_0;

  // driver: called at a falling edge where the ring is in fetch
  task automatic run_instr(input logic [15:0] ins, input logic z);
    instr = ins;
    acc_zero = z;
    exp_q.push_back(FETCH_W);                  tag_q.push_back("R3");
    exp_q.push_back(DECODE_W);                 tag_q.push_back("R4");
    exp_q.push_back(exp_exec(ins[15:12], z));  tag_q.push_back(exec_tag(ins[15:12]));
    repeat (3) @(negedge clk);
  endtask

  task automatic direct(input string tag, input logic [15:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (actual() !== e) begin
        fails++;
        $display("FAIL %s instr=%h z=%0b actual=%h expected=%h", t, instr, acc_zero, actual(), e);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #5;
    // R1: reset state is fetch
    direct("R1", FETCH_W);
    @(negedge clk);
    rst = 0;
    // R2 R3..R10: every opcode with both flag values and varied low bytes
    for (int o = 0; o < 16; o++) begin
      for (int z = 0; z < 2; z++) begin
        run_instr({o[3:0], 4'(o * 3 + z), 8'(o * 17 + z * 85)}, z[0]);
      end
    end
    // R10: low 12 bits and flag on non-jumps have no effect
    run_instr(16'h1FFF, 1'b1);
    run_instr(16'h5000, 1'b1);
    run_instr(16'hA0FF, 1'b0);
    run_instr(16'h9000, 1'b0);
    // R1: reset in mid-instruction returns to fetch
    instr = 16'h2055;
    @(negedge clk);
    #5;
    direct("R2", DECODE_W);
    rst = 1;
    @(negedge clk);
    #5;
    direct("R1", FETCH_W);
    @(negedge clk);
    rst = 0;
    run_instr(16'h8042, 1'b0);
    run_instr(16'h3033, 1'b1);
    // R2: ring keeps rotating back to fetch
    #5;
    direct("R2", FETCH_W);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule